// File: doc/BRIEF.md
# GPIO Port with Edge Interrupts

This block is one eight-pin slice of a general-purpose I/O controller. Software reaches it through a small 32-bit register interface: an address, a write strobe, write data and read data that can always be sampled. For each pin the slice stores an output value, a two-bit drive mode and a pull-up control. From these it produces the pad controls: the output level, the output enable and the pull-up enable.

Every pad input first passes through a two-stage synchroniser. The synchronised level can be read back. It also feeds an edge detector, and each pin chooses whether that detector watches for rising or for falling edges. A detected edge latches into a per-pin event bit. A test force register can also set an event bit. Software clears event bits by writing ones. A per-pin enable masks the events into a single interrupt line for the port. The register interface only carries control and status, so it uses plain strobes and has no valid/ready handshake. A write takes effect at the clock edge where `reg_we` is sampled high.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every register reads zero, `pad_oe` is 0, `pad_pull_en` is all ones and `irq` is 0.
- R2: Offset 0x04 returns the synchronised pin levels in bits 7:0, two clock edges after a pin changes. Bits 31:8 read zero. Writes to 0x04 have no effect.
- R3: Offsets 0x08 (output value), 0x10 (pull control), 0x18 (enable), 0x1C (force) and 0x20 (edge select) store write-data bits 7:0. Offset 0x0C (drive mode) stores bits 15:0. The unused upper bits read zero, and undefined offsets read zero.
- R4: The drive mode of pin n is held in bits 2n+1:2n of offset 0x0C. Code 00 is input and never enables the driver. Code 01 is push-pull and always enables the driver. Code 10 is open-drain and enables the driver only while the output bit is 0. Code 11 is open-source and enables the driver only while the output bit is 1.
- R5: `pad_out[n]` equals bit n of the output value register.
- R6: `pad_pull_en[n]` is the inverse of bit n of the pull register (0 means the pull-up is on).
- R7: Bit n of the edge-select register chooses the edge for pin n: 0 means falling, 1 means rising. Only the selected edge sets event bit n. The event is visible at offset 0x14 three clock edges after the pin changes, whatever the enable bit is.
- R8: Writing to offset 0x14 clears each event bit whose write-data bit is 1. Bits written 0 keep their state, and write-data bits 31:8 are ignored.
- R9: If an event bit is cleared in the same cycle that a new edge or force sets it, the bit ends up set.
- R10: While bit n of the force register is 1, event bit n is set on every cycle. Writing 0 to the force register stops the forcing.
- R11: `irq` is 1 exactly when some pin has both its event bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register byte offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output level |
| pad_oe | output | 8 | Pad output driver enable |
| pad_pull_en | output | 8 | Pad pull-up enable |
| irq | output | 1 | Port interrupt |

## Verification
The hardest case to reach from the ports is a clear write landing in exactly the cycle where a synchronised edge sets the same event bit. The bench reaches it by counting clock edges. It changes a pin at a falling clock edge, lets two rising edges carry the change through the synchroniser, and then asserts the clear strobe so that it is sampled at the third rising edge. The event bit was already set beforehand by a force pulse, so the check can only pass if the set wins over the clear. The same clear without an edge then confirms that the clear itself works.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    DRV_IN     = 2'b00,
    DRV_PUSH   = 2'b01,
    DRV_SINK   = 2'b10,
    DRV_SOURCE = 2'b11
  } drv_mode_e;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_DIN   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_DOUT  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_PULL  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_EVT   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_EN    = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_FORCE = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_EDGE  = 6'h20;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta_q;

  // Two synchroniser stages, plus one more flop so edges can be detected.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
      q_prev <= q;
    end
  end

  // q_prev must always hold the value q had one cycle earlier.
  p_prev_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_prev == $past(q)));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_port_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       dout,
  output logic       oe,
  output logic       out
);
  always_comb begin
    unique case (drv_mode_e'(mode))
      DRV_IN:     oe = 1'b0;
      DRV_PUSH:   oe = 1'b1;
      DRV_SINK:   oe = ~dout;
      DRV_SOURCE: oe = dout;
      default:    oe = 1'b0;
    endcase
  end

  assign out = dout;
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] lvl_prev,
  input  logic [N-1:0] rise_sel,
  input  logic [N-1:0] force_v,
  input  logic [N-1:0] clr_v,
  input  logic [N-1:0] en,
  output logic [N-1:0] evt,
  output logic         irq
);
  logic [N-1:0] rise, fall, hit, set_v;

  assign rise  = lvl & ~lvl_prev;
  assign fall  = ~lvl & lvl_prev;
  assign hit   = (rise & rise_sel) | (fall & ~rise_sel);
  assign set_v = hit | force_v;

  // When a set and a clear meet in the same cycle, the set takes priority.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= (evt & ~clr_v) | set_v;
  end

  assign irq = |(evt & en);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~evt & $past(set_v)) == '0));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt & $past(clr_v & ~set_v)) == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt ^ $past(evt)) == ($past(clr_v | set_v) & (evt ^ $past(evt)))));
  p_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
  p_edge_needs_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |-> (lvl != lvl_prev));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [5:0]               reg_addr,
  input  logic                     reg_we,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [N_PINS-1:0]        pin_in,
  output logic [N_PINS-1:0]        pad_out,
  output logic [N_PINS-1:0]        pad_oe,
  output logic [N_PINS-1:0]        pad_pull_en,
  output logic                     irq
);
  localparam int MODE_W = 2 * N_PINS;

  logic [N_PINS-1:0] dout_q, pull_q, en_q, force_q, edge_q;
  logic [MODE_W-1:0] mode_q;
  logic [N_PINS-1:0] lvl, lvl_prev, evt, clr_v;

  function automatic logic hit(input logic [5:0] ofs);
    return reg_we && (reg_addr == ofs);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      mode_q  <= '0;
      pull_q  <= '0;
      en_q    <= '0;
      force_q <= '0;
      edge_q  <= '0;
    end else begin
      if (hit(OFS_DOUT))  dout_q  <= reg_wdata[N_PINS-1:0];
      if (hit(OFS_MODE))  mode_q  <= reg_wdata[MODE_W-1:0];
      if (hit(OFS_PULL))  pull_q  <= reg_wdata[N_PINS-1:0];
      if (hit(OFS_EN))    en_q    <= reg_wdata[N_PINS-1:0];
      if (hit(OFS_FORCE)) force_q <= reg_wdata[N_PINS-1:0];
      if (hit(OFS_EDGE))  edge_q  <= reg_wdata[N_PINS-1:0];
    end
  end

  assign clr_v = hit(OFS_EVT) ? reg_wdata[N_PINS-1:0] : '0;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_DIN:   reg_rdata = 32'(lvl);
      OFS_DOUT:  reg_rdata = 32'(dout_q);
      OFS_MODE:  reg_rdata = 32'(mode_q);
      OFS_PULL:  reg_rdata = 32'(pull_q);
      OFS_EVT:   reg_rdata = 32'(evt);
      OFS_EN:    reg_rdata = 32'(en_q);
      OFS_FORCE: reg_rdata = 32'(force_q);
      OFS_EDGE:  reg_rdata = 32'(edge_q);
      default:   reg_rdata = '0;
    endcase
  end

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl), .q_prev(lvl_prev)
  );

  gpio_evt #(.N(N_PINS)) u_evt (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .lvl_prev(lvl_prev),
    .rise_sel(edge_q), .force_v(force_q), .clr_v(clr_v), .en(en_q),
    .evt(evt), .irq(irq)
  );

  assign pad_pull_en = ~pull_q;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    gpio_pad_drive u_drv (
      .mode(mode_q[2*i +: 2]), .dout(dout_q[i]),
      .oe(pad_oe[i]), .out(pad_out[i])
    );

    p_input_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == DRV_IN) |-> !pad_oe[i]);
    p_sink_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe[i] && mode_q[2*i +: 2] == DRV_SINK) |-> !pad_out[i]);
    p_source_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe[i] && mode_q[2*i +: 2] == DRV_SOURCE) |-> pad_out[i]);
    p_force_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
      force_q[i] |=> evt[i]);
  end
endmodule

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pad_out, pad_oe, pad_pull_en;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  gpio_edge_port dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_oe(input logic [15:0] m, input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      case (m[2*i +: 2])
        2'b00: r[i] = 1'b0;
        2'b01: r[i] = 1'b1;
        2'b10: r[i] = ~d[i];
        default: r[i] = d[i];
      endcase
    return r;
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 reset state
    for (int a = 4; a <= 32; a += 4) begin
      rd(6'(a), rv);
      chk("R1 reset reg", rv, 32'h0);
    end
    chk("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
    chk("R1 pad_pull_en", {24'h0, pad_pull_en}, 32'hFF);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R3 write/readback of storage registers
    wr(6'h08, 32'hFFFF_FFFF); rd(6'h08, rv); chk("R3 dout ones", rv, 32'hFF);
    wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, rv); chk("R3 mode ones", rv, 32'hFFFF);
    wr(6'h10, 32'hFFFF_FFFF); rd(6'h10, rv); chk("R3 pull ones", rv, 32'hFF);
    wr(6'h18, 32'hFFFF_FFFF); rd(6'h18, rv); chk("R3 en ones", rv, 32'hFF);
    wr(6'h20, 32'hFFFF_FFFF); rd(6'h20, rv); chk("R3 edge ones", rv, 32'hFF);
    rd(6'h24, rv); chk("R3 undefined offset", rv, 32'h0);
    chk("R11 no event no irq", {31'h0, irq}, 32'h0);
    wr(6'h08, 32'h5A); wr(6'h0C, 32'h1234); wr(6'h10, 32'h0);
    wr(6'h18, 32'h0); wr(6'h20, 32'h0);
    rd(6'h0C, rv); chk("R3 mode pattern", rv, 32'h1234);
    rd(6'h08, rv); chk("R3 dout pattern", rv, 32'h5A);

    // R4 / R5 drive modes swept across uniform and mixed codes
    for (int m = 0; m < 5; m++) begin
      logic [15:0] mv;
      mv = (m < 4) ? {8{2'(m)}} : 16'hE4E4;
      wr(6'h0C, {16'h0, mv});
      for (int k = 0; k < 4; k++) begin
        logic [7:0] dv;
        dv = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h5A : 8'hC3;
        wr(6'h08, {24'h0, dv});
        chk("R4 pad_oe", {24'h0, pad_oe}, {24'h0, exp_oe(mv, dv)});
        chk("R5 pad_out", {24'h0, pad_out}, {24'h0, dv});
      end
    end
    wr(6'h0C, 32'h0); wr(6'h08, 32'h0);

    // R6 pull control exhaustive
    for (int v = 0; v < 256; v++) begin
      wr(6'h10, 32'(v));
      chk("R6 pull", {24'h0, pad_pull_en}, {24'h0, ~8'(v)});
    end
    wr(6'h10, 32'h0);

    // R2 input data exhaustive, two edge latency
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); pin_in = 8'(v);
      settle(2);
      rd(6'h04, rv);
      chk("R2 din", rv, 32'(v));
    end
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, rv); chk("R2 din write ignored", rv, 32'hFF);
    @(negedge clk); pin_in = 8'h00;
    settle(4);
    wr(6'h14, 32'hFF);

    // R7 per-pin edge polarity sweep, enable off
    for (int pol = 0; pol < 2; pol++) begin
      wr(6'h20, pol ? 32'hFF : 32'h0);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); pin_in[i] = 1'b1;
        settle(3);
        rd(6'h14, rv);
        chk("R7 rising", rv, pol ? 32'(1 << i) : 32'h0);
        chk("R11 masked irq", {31'h0, irq}, 32'h0);
        wr(6'h14, 32'hFF);
        @(negedge clk); pin_in[i] = 1'b0;
        settle(3);
        rd(6'h14, rv);
        chk("R7 falling", rv, pol ? 32'h0 : 32'(1 << i));
        wr(6'h14, 32'hFF);
      end
    end
    wr(6'h20, 32'h0);

    // R10 force, with clear during force (R9)
    wr(6'h1C, 32'h3C);
    rd(6'h1C, rv); chk("R10 force readback", rv, 32'h3C);
    settle(1);
    rd(6'h14, rv); chk("R10 forced events", rv, 32'h3C);
    wr(6'h14, 32'hFF);
    rd(6'h14, rv); chk("R9 clear under force", rv, 32'h3C);
    wr(6'h1C, 32'h0);
    wr(6'h14, 32'hFF);
    rd(6'h14, rv); chk("R10 force stopped", rv, 32'h0);

    // R8 write-one-to-clear
    wr(6'h1C, 32'hFF); wr(6'h1C, 32'h0);
    rd(6'h14, rv); chk("R8 all pending", rv, 32'hFF);
    wr(6'h14, 32'hFFFF_FF00);
    rd(6'h14, rv); chk("R8 upper bits ignored", rv, 32'hFF);
    wr(6'h14, 32'h0F);
    rd(6'h14, rv); chk("R8 partial clear", rv, 32'hF0);

    // R11 enable sweep over events F0
    for (int i = 0; i < 8; i++) begin
      wr(6'h18, 32'(1 << i));
      chk("R11 irq per pin", {31'h0, irq}, {31'h0, (i >= 4)});
    end
    wr(6'h18, 32'h0);
    chk("R11 irq disabled", {31'h0, irq}, 32'h0);
    wr(6'h14, 32'hFF);

    // R9 edge set meeting a clear in the same cycle
    wr(6'h1C, 32'h01); wr(6'h1C, 32'h0);
    @(negedge clk); pin_in[0] = 1'b1;   // falling-edge select: use falling
    settle(4);
    wr(6'h14, 32'hFF);
    @(negedge clk); pin_in[0] = 1'b0;   // edge seen at third rising edge
    @(negedge clk);
    @(negedge clk);
    reg_addr = 6'h14; reg_wdata = 32'h01; reg_we = 1'b1;
    wr(6'h1C, 32'h01); wr(6'h1C, 32'h0);
    rd(6'h14, rv); chk("R9 pre-set by force", rv, 32'h01);
    @(negedge clk); pin_in[0] = 1'b1;
    settle(4);
    wr(6'h14, 32'hFF);
    wr(6'h1C, 32'h01); wr(6'h1C, 32'h0);
    @(negedge clk); pin_in[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 6'h14; reg_wdata = 32'h01; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    rd(6'h14, rv); chk("R9 set beats clear", rv, 32'h01);
    wr(6'h14, 32'h01);
    rd(6'h14, rv); chk("R8 plain clear", rv, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule